// File: doc/BRIEF.md
# Shift, Round, Cascade-Add and Rectify Input Stage

This block conditions a signed word that arrives each cycle from a multiply-accumulate array. An arithmetic barrel shifter first scales the word. Right shifts are rounded: the last bit shifted out is carried into a cascade adder. Left shifts simply wrap. The adder adds the scaled word, the rounding carry and a second operand. That operand is either a cascade word from a neighbouring stage or zero. The adder flags results that fall outside the signed word range.

A rectifier then passes the sum unchanged, takes its magnitude, or clamps negative values to zero. The result and the two overflow flags are registered together and appear one clock after the inputs. All configuration is held on static control inputs.

Top module: `sar_input_stage`

## Requirements
- R1: With `shift_ctl[MAG_W]` = 0 the word is shifted left by the magnitude in `shift_ctl[MAG_W-1:0]`. Bits leaving the top are dropped, so the result wraps to DATA_W bits. No rounding carry is added, and a left shift raises no overflow flag unless the cascade operand pushes the sum out of range.
- R2: With `shift_ctl[MAG_W]` = 1 the word is shifted right arithmetically (sign-filled). The most significant bit shifted out, which is `din[n-1]` for magnitude n ≥ 1, is added to the sum as a carry, giving round-half-up. A magnitude of 0 adds no carry.
- R3: A magnitude field above MAX_SHIFT acts as MAX_SHIFT in either direction.
- R4: `use_casc` = 1 adds `casc_in` (signed) to the sum; `use_casc` = 0 adds zero. With `use_casc` = 0 neither overflow flag ever rises.
- R5: `pos_ovf` is 1 when the exact sum exceeds 2^(DATA_W-1)-1. In that case the output carries the sum wrapped to DATA_W bits before rectification.
- R6: `neg_ovf` is 1 when the exact sum is below -2^(DATA_W-1). The output again carries the wrapped sum, and the two flags are never both 1.
- R7: `rect_mode` 2'b00 and 2'b11 pass the sum unchanged. 2'b01 outputs the magnitude of the sum. 2'b10 outputs zero for a negative sum and the sum itself otherwise.
- R8: In magnitude mode (2'b01) a sum equal to -2^(DATA_W-1) is output unchanged as -2^(DATA_W-1).
- R9: Output and flags for the inputs present at clock edge k appear together after edge k and hold until edge k+1.
- R10: While `rst` is 1 at a rising edge, `x_out`, `pos_ovf` and `neg_ovf` become 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Signed word from the accumulator array |
| shift_ctl | input | MAG_W+1 | Top bit: 1 = right, 0 = left; lower bits: shift magnitude |
| use_casc | input | 1 | 1 adds the cascade word, 0 adds zero |
| casc_in | input | DATA_W | Signed cascade word |
| rect_mode | input | 2 | 00/11 pass, 01 magnitude, 10 negative-to-zero |
| x_out | output | DATA_W | Registered conditioned word |
| pos_ovf | output | 1 | Registered positive overflow flag |
| neg_ovf | output | 1 | Registered negative overflow flag |

## Verification
The bench builds the stage with DATA_W = 8 and MAX_SHIFT = 4. This makes MAG_W = 3, so magnitude codes 5 to 7 exercise the clamp. Every 8-bit input is swept against every shift code, which covers wrapping left shifts and each rounding position. Every input is also swept against a stride of cascade words under all four rectifier codes, which covers both overflow directions and the most negative sum under magnitude mode. A further sweep pairs every shift code with extreme cascade words, and a reset is applied mid-run.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        RECT_PASS     = 2'b00,
        RECT_FULL     = 2'b01,
        RECT_HALF     = 2'b10,
        RECT_PASS_ALT = 2'b11
    } rect_mode_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } ovf_flags_t;

    localparam int DEFAULT_DATA_W    = 22;
    localparam int DEFAULT_MAX_SHIFT = 8;

endpackage

// File: rtl/sar_shifter.sv
module sar_shifter #(
    parameter int DATA_W    = 22,
    parameter int MAX_SHIFT = 8,
    parameter int MAG_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic [DATA_W-1:0] din,
    input  logic              dir_right,
    input  logic [MAG_W-1:0]  mag,
    output logic [DATA_W-1:0] dout,
    output logic              round_bit
);

    logic [DATA_W-1:0] left_c  [MAX_SHIFT+1];
    logic [DATA_W-1:0] right_c [MAX_SHIFT+1];
    logic [MAX_SHIFT:0] rnd_c;
    logic [MAG_W-1:0]  amt;

    // One candidate per shift distance; the clamped amount picks one.
    for (genvar k = 0; k <= MAX_SHIFT; k++) begin : g_cand
        assign left_c[k]  = din << k;
        assign right_c[k] = $signed(din) >>> k;
        if (k == 0) begin : g_zero
            assign rnd_c[k] = 1'b0;
        end else begin : g_rnd
            assign rnd_c[k] = din[k-1];
        end
    end

    always_comb begin
        amt       = (mag > MAG_W'(MAX_SHIFT)) ? MAG_W'(MAX_SHIFT) : mag;
        dout      = dir_right ? right_c[amt] : left_c[amt];
        round_bit = dir_right & rnd_c[amt];
    end

endmodule

// File: rtl/sar_cascade_add.sv
module sar_cascade_add
    import sar_pkg::*;
#(
    parameter int DATA_W = 22
) (
    input  logic [DATA_W-1:0] a,
    input  logic              carry_in,
    input  logic              use_casc,
    input  logic [DATA_W-1:0] casc,
    output logic [DATA_W-1:0] sum,
    output ovf_flags_t        flags
);

    localparam int SW = DATA_W + 2;
    localparam logic signed [SW-1:0] POS_LIM = SW'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [SW-1:0] NEG_LIM = -POS_LIM - SW'(1);

    logic signed [SW-1:0] ext_a;
    logic signed [SW-1:0] ext_c;
    logic signed [SW-1:0] ext_r;
    logic signed [SW-1:0] full;

    always_comb begin
        ext_a     = SW'($signed(a));
        ext_c     = use_casc ? SW'($signed(casc)) : '0;
        ext_r     = $signed({{(SW-1){1'b0}}, carry_in});
        full      = ext_a + ext_c + ext_r;
        sum       = full[DATA_W-1:0];
        flags.pos = full > POS_LIM;
        flags.neg = full < NEG_LIM;
    end

endmodule

// File: rtl/sar_rectifier.sv
module sar_rectifier
    import sar_pkg::*;
#(
    parameter int DATA_W = 22
) (
    input  logic [DATA_W-1:0] din,
    input  rect_mode_e        mode,
    output logic [DATA_W-1:0] dout
);

    logic is_neg;

    always_comb begin
        is_neg = din[DATA_W-1];
        unique case (mode)
            RECT_FULL: dout = is_neg ? (~din + DATA_W'(1)) : din;
            RECT_HALF: dout = is_neg ? '0 : din;
            default:   dout = din;
        endcase
    end

endmodule

// File: rtl/sar_input_stage.sv
module sar_input_stage
    import sar_pkg::*;
#(
    parameter int DATA_W    = DEFAULT_DATA_W,
    parameter int MAX_SHIFT = DEFAULT_MAX_SHIFT,
    parameter int MAG_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [MAG_W:0]    shift_ctl,
    input  logic              use_casc,
    input  logic [DATA_W-1:0] casc_in,
    input  logic [1:0]        rect_mode,
    output logic [DATA_W-1:0] x_out,
    output logic              pos_ovf,
    output logic              neg_ovf
);

    logic [DATA_W-1:0] shifted;
    logic              rnd;
    logic [DATA_W-1:0] sum;
    ovf_flags_t        flags;
    logic [DATA_W-1:0] rect;

    sar_shifter #(
        .DATA_W    (DATA_W),
        .MAX_SHIFT (MAX_SHIFT),
        .MAG_W     (MAG_W)
    ) u_shift (
        .din       (din),
        .dir_right (shift_ctl[MAG_W]),
        .mag       (shift_ctl[MAG_W-1:0]),
        .dout      (shifted),
        .round_bit (rnd)
    );

    sar_cascade_add #(
        .DATA_W (DATA_W)
    ) u_add (
        .a        (shifted),
        .carry_in (rnd),
        .use_casc (use_casc),
        .casc     (casc_in),
        .sum      (sum),
        .flags    (flags)
    );

    sar_rectifier #(
        .DATA_W (DATA_W)
    ) u_rect (
        .din  (sum),
        .mode (rect_mode_e'(rect_mode)),
        .dout (rect)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_out   <= '0;
            pos_ovf <= 1'b0;
            neg_ovf <= 1'b0;
        end else begin
            x_out   <= rect;
            pos_ovf <= flags.pos;
            neg_ovf <= flags.neg;
        end
    end

endmodule

// File: rtl/sar_input_stage_chk.sv
module sar_input_stage_chk #(
    parameter int DATA_W = 22,
    parameter int MAG_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              use_casc,
    input logic [1:0]        rect_mode,
    input logic [DATA_W-1:0] x_out,
    input logic              pos_ovf,
    input logic              neg_ovf
);

    localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (x_out == '0 && !pos_ovf && !neg_ovf));

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(pos_ovf && neg_ovf));

    // R4
    no_casc_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        !use_casc |=> (!pos_ovf && !neg_ovf));

    // R7
    half_wave_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (rect_mode == 2'b10) |=> !x_out[DATA_W-1]);

    // R8
    full_wave_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (rect_mode == 2'b01) |=> (!x_out[DATA_W-1] || x_out == MIN_V));

endmodule

bind sar_input_stage sar_input_stage_chk #(
    .DATA_W (DATA_W),
    .MAG_W  (MAG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .use_casc  (use_casc),
    .rect_mode (rect_mode),
    .x_out     (x_out),
    .pos_ovf   (pos_ovf),
    .neg_ovf   (neg_ovf)
);

// File: tb/sar_input_stage_tb.sv
module sar_input_stage_tb;

    localparam int W     = 8;
    localparam int MAXS  = 4;
    localparam int MW    = $clog2(MAXS + 1);
    localparam int CODES = 2 ** (MW + 1);
    localparam int WD    = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  din;
    logic [MW:0]   shift_ctl;
    logic          use_casc;
    logic [W-1:0]  casc_in;
    logic [1:0]    rect_mode;
    logic [W-1:0]  x_out;
    logic          pos_ovf;
    logic          neg_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sar_input_stage #(
        .DATA_W    (W),
        .MAX_SHIFT (MAXS)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .shift_ctl (shift_ctl),
        .use_casc  (use_casc),
        .casc_in   (casc_in),
        .rect_mode (rect_mode),
        .x_out     (x_out),
        .pos_ovf   (pos_ovf),
        .neg_ovf   (neg_ovf)
    );

    function automatic int sext(input int v);
        return ((v & ((1 << W) - 1)) ^ (1 << (W - 1))) - (1 << (W - 1));
    endfunction

    task automatic model(input int d, input int code, input bit uc, input int c,
                         input int mode, output int ex, output bit ep, output bit en);
        int n;
        int sh;
        int rnd;
        int s;
        int w;
        n   = code & ((1 << MW) - 1);
        if (n > MAXS) n = MAXS;
        rnd = 0;
        if (((code >> MW) & 1) == 1) begin
            sh = d >>> n;
            if (n > 0) rnd = (d >>> (n - 1)) & 1;
        end else begin
            sh = sext(d << n);
        end
        s  = sh + rnd + (uc ? c : 0);
        ep = s > (1 << (W - 1)) - 1;
        en = s < -(1 << (W - 1));
        w  = sext(s);
        if (mode == 1)      ex = (w < 0) ? sext(-w) : w;
        else if (mode == 2) ex = (w < 0) ? 0 : w;
        else                ex = w;
    endtask

    // Drive on a falling edge, let one rising edge register, check on the next falling edge (R9).
    task automatic run_vec(input int d, input int code, input bit uc, input int c,
                           input int mode, input string req);
        int ex;
        bit ep;
        bit en;
        model(d, code, uc, c, mode, ex, ep, en);
        din       = W'(d);
        shift_ctl = (MW + 1)'(code);
        use_casc  = uc;
        casc_in   = W'(c);
        rect_mode = 2'(mode);
        @(negedge clk);
        checks++;
        if (int'($signed(x_out)) != ex || pos_ovf != ep || neg_ovf != en) begin
            fails++;
            $display("FAIL %s d=%0d code=%0d uc=%0d c=%0d mode=%0d: got x=%0d p=%0d n=%0d exp x=%0d p=%0d n=%0d",
                     req, d, code, uc, c, mode, $signed(x_out), pos_ovf, neg_ovf, ex, ep, en);
        end
    endtask

    task automatic check_reset(input string req);
        checks++;
        if (x_out != '0 || pos_ovf || neg_ovf) begin
            fails++;
            $display("FAIL %s reset: got x=%0d p=%0d n=%0d exp x=0 p=0 n=0",
                     req, x_out, pos_ovf, neg_ovf);
        end
    endtask

    initial begin
        for (int i = 0; i < WD; i++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; din = '0; shift_ctl = '0; use_casc = 1'b0; casc_in = '0; rect_mode = 2'b00;
        @(negedge clk);
        din = 8'h7F; use_casc = 1'b1; casc_in = 8'h7F;
        @(negedge clk);
        check_reset("R10");
        rst = 1'b0;

        // R1 R2 R3: every input against every shift code, no cascade, pass-through.
        for (int d = -128; d < 128; d++)
            for (int code = 0; code < CODES; code++)
                run_vec(d, code, 1'b0, 0, 0, "R1/R2/R3");

        // R4 R5 R6 R7 R8: every input, stride of cascade words, all rectifier codes.
        for (int m = 0; m < 4; m++)
            for (int d = -128; d < 128; d++)
                for (int c = -128; c < 128; c += 8)
                    run_vec(d, 0, 1'b1, c, m, "R4/R5/R6/R7");

        // R8: most negative sum under magnitude mode.
        run_vec(-128, 0, 1'b1, 0, 1, "R8");
        run_vec(-64, 0, 1'b1, -64, 1, "R8");

        // R5 R6 with rounding and clamped shifts against extreme cascade words.
        for (int d = -128; d < 128; d++)
            for (int code = 0; code < CODES; code++) begin
                run_vec(d, code, 1'b1, 127, 0, "R5");
                run_vec(d, code, 1'b1, -128, 2, "R6");
            end

        // R10: reset mid-run after an overflowing vector.
        run_vec(127, 0, 1'b1, 127, 0, "R5");
        rst = 1'b1;
        @(negedge clk);
        check_reset("R10");
        rst = 1'b0;
        run_vec(5, 9, 1'b0, 0, 3, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule